// File: doc/BRIEF.md
# Cell-Aware Output Buffer with Selectable Width

This block sits at the end of a receive path. It collects ATM cells one byte at a time from an upstream writer and stores up to four whole cells. It hands them to a downstream reader one transfer per read cycle. Each incoming cell opens with a byte flagged by `in_sop`. The block only offers a cell to the reader once that cell's last byte is stored. When every slot is taken, a newly arriving cell is discarded as a whole and counted.

The read side runs at one of two widths, chosen by `narrow_mode`. In byte mode, each cell is read as 53 transfers on the low byte of the bus. In word mode, each cell is read as 27 sixteen-bit words. In word mode a zero pad byte follows the 5-byte header, so the payload starts on a word boundary. Output data is presented ahead of the read: the current transfer is visible on `rd_data` and is consumed at a rising clock edge while `rd_en_n` is low.

Writer and reader share one clock. The width mode is meant to be set while reset is held. Cells in flight across a mode change are not preserved.

Top module: `cell_out_fifo`

## Requirements
- R1: With `narrow_mode` high, a cell is read as 53 transfers. The cell bytes appear on `rd_data[7:0]` in arrival order, and `rd_data[15:8]` is 0.
- R2: With `narrow_mode` low, a cell is read as 27 words. The bytes are laid out as header bytes 0..4, a zero pad byte, then payload bytes 5..52. Word k carries position 2k on bits [7:0] and position 2k+1 on bits [15:8]. The first word therefore holds header byte 0 in its low half and header byte 1 in its high half. Bit 0 is the least significant bit.
- R3: `rd_sop` is high exactly while the first transfer of a cell is presented, and low for the rest of that cell.
- R4: `cell_ready` is high only while at least one complete cell is stored. It rises in the cycle after the cell's last byte is written, and a partially written cell never raises it.
- R5: While `cell_ready` is low, `rd_data` is 0. Reads issued with `rd_en_n` low have no effect, so the next stored cell still starts at its first transfer.
- R6: When four cells are stored, a newly arriving cell is dropped entirely and `drop_count` increments by one. The stored cells are read back unchanged.
- R7: Reset (active-low `rst_n`) empties the buffer and clears `drop_count`. After reset, `cell_ready`, `rd_sop` and `rd_data` are 0.
- R8: Cells are read out in the order they were completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared write and read clock |
| rst_n | input | 1 | Active-low reset, flushes all stored cells |
| narrow_mode | input | 1 | 1 selects byte-wide output, 0 selects 16-bit output |
| in_valid | input | 1 | Writer presents a cell byte this cycle |
| in_sop | input | 1 | Byte presented is the first byte of a cell |
| in_byte | input | 8 | Cell byte from the writer |
| rd_en_n | input | 1 | Active-low read enable, consumes the presented transfer |
| rd_data | output | 16 | Presented transfer; 0 when no cell is ready |
| rd_sop | output | 1 | High on the first transfer of a cell |
| cell_ready | output | 1 | At least one complete cell is stored |
| drop_count | output | 8 | Number of cells dropped for lack of space (wraps) |

## Verification
Every cell carries a distinct arithmetic byte sequence, so a transfer that is skipped, repeated, misordered or taken from the wrong slot shows up as a data mismatch against the scoreboard. Single cells and back-to-back cells are read in both widths. Word mode is what separates a correct pad insertion and byte lane order from a shifted or swapped layout. Holding the read enable low before any cell exists, and then checking that the first cell still opens with its start marker, distinguishes an ignored read from one that moves the pointer. Writing five cells into four slots separates a whole-cell drop from a partial overwrite, and a reset with cells stored shows that the flush is complete.

// File: rtl/cof_pkg.sv
package cof_pkg;
  // Slot position of an incoming byte index: one pad byte follows the header.
  function automatic int unsigned byte_slot_pos(input int unsigned idx, input int unsigned hdr);
    return (idx < hdr) ? idx : idx + 1;
  endfunction

  // Next position for byte-wide reading: the pad position is skipped.
  function automatic int unsigned next_narrow_pos(input int unsigned pos, input int unsigned hdr);
    return (pos + 1 == hdr) ? pos + 2 : pos + 1;
  endfunction

  // True when a slot position holds the pad byte.
  function automatic bit is_pad_pos(input int unsigned pos, input int unsigned hdr);
    return pos == hdr;
  endfunction

  function automatic int unsigned wrap_slot(input int unsigned s, input int unsigned n);
    return (s + 1 >= n) ? 0 : s + 1;
  endfunction
endpackage

// File: rtl/cof_writer.sv
module cof_writer #(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 5,
  parameter int SLOTS      = 4,
  parameter int SLOT_POS   = 54,
  parameter int ADDR_W     = 8,
  parameter int OCC_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [OCC_W-1:0]  occ,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic              commit_evt,
  output logic              drop_evt
);
  localparam int IDX_W  = $clog2(CELL_BYTES);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic              active;
  logic [IDX_W-1:0]  idx;
  logic [SLOT_W-1:0] slot;
  logic              has_room, start, cont;
  logic [IDX_W-1:0]  idx_now;

  always_comb begin
    has_room   = occ < OCC_W'(SLOTS);
    start      = in_valid && in_sop && has_room;
    drop_evt   = in_valid && in_sop && !has_room;
    cont       = in_valid && !in_sop && active;
    we         = start || cont;
    idx_now    = start ? '0 : idx;
    commit_evt = cont && (32'(idx) == CELL_BYTES - 1);
    waddr      = ADDR_W'(32'(slot) * SLOT_POS
                 + cof_pkg::byte_slot_pos(32'(idx_now), HDR_BYTES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      slot   <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= IDX_W'(1);
    end else if (drop_evt) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (commit_evt) begin
      active <= 1'b0;
      idx    <= '0;
      slot   <= SLOT_W'(cof_pkg::wrap_slot(32'(slot), SLOTS));
    end else if (cont) begin
      idx    <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/cof_store.sv
module cof_store #(
  parameter int DEPTH  = 216,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        lo_byte,
  output logic [7:0]        hi_byte
);
  logic [7:0] mem [DEPTH];
  logic [ADDR_W-1:0] raddr_hi;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    raddr_hi = raddr + 1'b1;
    lo_byte  = (32'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
    hi_byte  = (32'(raddr_hi) < DEPTH) ? mem[raddr_hi] : 8'h00;
  end
endmodule

// File: rtl/cof_reader.sv
module cof_reader #(
  parameter int HDR_BYTES = 5,
  parameter int SLOTS     = 4,
  parameter int SLOT_POS  = 54,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow_mode,
  input  logic              rd_en_n,
  input  logic              avail,
  input  logic [7:0]        lo_byte,
  input  logic [7:0]        hi_byte,
  output logic [ADDR_W-1:0] raddr,
  output logic [15:0]       rd_data,
  output logic              rd_sop,
  output logic              done_evt
);
  localparam int POS_W  = $clog2(SLOT_POS);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [POS_W-1:0]  pos;
  logic [SLOT_W-1:0] slot;
  logic [7:0]        lo_v, hi_v;
  logic              fire, last;

  always_comb begin
    raddr    = ADDR_W'(32'(slot) * SLOT_POS + 32'(pos));
    lo_v     = cof_pkg::is_pad_pos(32'(pos), HDR_BYTES) ? 8'h00 : lo_byte;
    hi_v     = cof_pkg::is_pad_pos(32'(pos) + 1, HDR_BYTES) ? 8'h00 : hi_byte;
    rd_data  = !avail ? 16'h0000 : (narrow_mode ? {8'h00, lo_v} : {hi_v, lo_v});
    rd_sop   = avail && (pos == '0);
    fire     = avail && !rd_en_n;
    last     = narrow_mode ? (32'(pos) >= SLOT_POS - 1) : (32'(pos) >= SLOT_POS - 2);
    done_evt = fire && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      slot <= '0;
    end else if (fire) begin
      if (last) begin
        pos  <= '0;
        slot <= SLOT_W'(cof_pkg::wrap_slot(32'(slot), SLOTS));
      end else if (narrow_mode) begin
        pos  <= POS_W'(cof_pkg::next_narrow_pos(32'(pos), HDR_BYTES));
      end else begin
        pos  <= pos + POS_W'(2);
      end
    end
  end
endmodule

// File: rtl/cell_out_fifo.sv
module cell_out_fifo #(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 5,
  parameter int SLOTS      = 4,
  parameter int DROP_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow_mode,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [7:0]        in_byte,
  input  logic              rd_en_n,
  output logic [15:0]       rd_data,
  output logic              rd_sop,
  output logic              cell_ready,
  output logic [DROP_W-1:0] drop_count
);
  localparam int SLOT_POS = CELL_BYTES + 1;
  localparam int DEPTH    = SLOTS * SLOT_POS;
  localparam int ADDR_W   = $clog2(DEPTH + 1);
  localparam int OCC_W    = $clog2(SLOTS + 1);

  logic [OCC_W-1:0]  occ;
  logic              we, commit_evt, drop_evt, done_evt;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [7:0]        lo_byte, hi_byte;

  assign cell_ready = (occ != '0);

  cof_writer #(.CELL_BYTES(CELL_BYTES), .HDR_BYTES(HDR_BYTES), .SLOTS(SLOTS),
               .SLOT_POS(SLOT_POS), .ADDR_W(ADDR_W), .OCC_W(OCC_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .occ(occ),
    .we(we), .waddr(waddr), .commit_evt(commit_evt), .drop_evt(drop_evt));

  cof_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(in_byte), .raddr(raddr),
    .lo_byte(lo_byte), .hi_byte(hi_byte));

  cof_reader #(.HDR_BYTES(HDR_BYTES), .SLOTS(SLOTS), .SLOT_POS(SLOT_POS),
               .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode), .rd_en_n(rd_en_n),
    .avail(cell_ready), .lo_byte(lo_byte), .hi_byte(hi_byte), .raddr(raddr),
    .rd_data(rd_data), .rd_sop(rd_sop), .done_evt(done_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ        <= '0;
      drop_count <= '0;
    end else begin
      case ({commit_evt, done_evt})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      if (drop_evt) drop_count <= drop_count + 1'b1;
    end
  end
endmodule

// File: rtl/cof_chk.sv
module cof_chk #(
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en_n,
  input logic              cell_ready,
  input logic              rd_sop,
  input logic [15:0]       rd_data,
  input logic [DROP_W-1:0] drop_count,
  input logic              commit_evt
);
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_ready |-> rd_data == 16'h0000);

  assert_sop_needs_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sop |-> cell_ready);

  assert_sop_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sop && !rd_en_n) |=> !rd_sop);

  assert_ready_from_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cell_ready) |-> $past(commit_evt));

  assert_hold_unread_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_ready && rd_en_n) |=> (cell_ready && $stable(rd_data) && $stable(rd_sop)));

  assert_drop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));
endmodule

bind cell_out_fifo cof_chk #(.DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .cell_ready(cell_ready),
  .rd_sop(rd_sop), .rd_data(rd_data), .drop_count(drop_count),
  .commit_evt(commit_evt));

// File: tb/cell_out_fifo_tb.sv
module cell_out_fifo_tb;
  localparam int NB = 53;
  localparam int HB = 5;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        narrow_mode = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sop = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        rd_en_n = 1'b1;
  logic [15:0] rd_data;
  logic        rd_sop;
  logic        cell_ready;
  logic [7:0]  drop_count;

  int errors = 0;
  int checks = 0;
  int stored = 0;
  logic [16:0] sb [$];

  always #10 clk = ~clk;

  cell_out_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode), .in_valid(in_valid),
    .in_sop(in_sop), .in_byte(in_byte), .rd_en_n(rd_en_n), .rd_data(rd_data),
    .rd_sop(rd_sop), .cell_ready(cell_ready), .drop_count(drop_count));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    narrow_mode = mode;
    rd_en_n = 1'b1;
    in_valid = 1'b0;
    sb.delete();
    stored = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Driver: writes one cell and pushes the transfers the reader should see.
  task automatic write_cell(input logic [7:0] seed, input bit partial_chk);
    logic [7:0] lay [NB+1];
    bit keep;
    keep = (stored < NS);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      if (partial_chk && i == NB - 1) chk("R4 partial", 32'(cell_ready), 0);
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_byte  = seed + 8'(i * 7);
      lay[(i < HB) ? i : i + 1] = in_byte;
    end
    lay[HB] = 8'h00;
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
    if (keep) begin
      stored++;
      if (narrow_mode) begin
        for (int i = 0; i < NB; i++)
          sb.push_back({(i == 0), 8'h00, seed + 8'(i * 7)});
      end else begin
        for (int k = 0; k < (NB + 1) / 2; k++)
          sb.push_back({(k == 0), lay[2*k+1], lay[2*k]});
      end
    end
  endtask

  // Monitor: reads n cells, comparing each presented transfer to the scoreboard.
  task automatic read_cells(input int n);
    int per;
    logic [16:0] e;
    per = narrow_mode ? NB : (NB + 1) / 2;
    for (int c = 0; c < n; c++) begin
      for (int k = 0; k < per; k++) begin
        @(negedge clk);
        e = sb.pop_front();
        chk("R4 ready", 32'(cell_ready), 1);
        chk(narrow_mode ? "R1 data" : "R2 data", 32'(rd_data), 32'(e[15:0]));
        chk("R3 sop", 32'(rd_sop), 32'(e[16]));
        rd_en_n = 1'b0;
      end
      stored--;
    end
    @(negedge clk);
    rd_en_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R7: reset state
    do_reset(1'b1);
    @(negedge clk);
    chk("R7 ready", 32'(cell_ready), 0);
    chk("R7 sop", 32'(rd_sop), 0);
    chk("R7 data", 32'(rd_data), 0);
    chk("R7 drops", 32'(drop_count), 0);

    // R5: reads with no cell are ignored and data stays 0
    rd_en_n = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R5 idle data", 32'(rd_data), 0);
    end
    rd_en_n = 1'b1;

    // R4 partial cell not offered, then ready one cycle after last byte; R1 byte mode
    write_cell(8'h10, 1'b1);
    chk("R4 ready after last", 32'(cell_ready), 1);
    chk("R5 first after idle reads", 32'(rd_sop), 1);
    read_cells(1);
    chk("R4 empty after read", 32'(cell_ready), 0);

    // R8 order, byte mode, two cells
    write_cell(8'h40, 1'b0);
    write_cell(8'h81, 1'b0);
    read_cells(2);
    chk("R8 drained", 32'(cell_ready), 0);

    // R2 word mode
    do_reset(1'b0);
    write_cell(8'h22, 1'b1);
    read_cells(1);

    // R6 overflow: five cells into four slots
    write_cell(8'h01, 1'b0);
    write_cell(8'h33, 1'b0);
    write_cell(8'h65, 1'b0);
    write_cell(8'h97, 1'b0);
    write_cell(8'hC9, 1'b0);
    chk("R6 drops", 32'(drop_count), 1);
    read_cells(4);
    chk("R6 dropped cell absent", 32'(cell_ready), 0);

    // R7 flush with cells stored
    write_cell(8'h5A, 1'b0);
    write_cell(8'hA5, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    sb.delete();
    stored = 0;
    @(negedge clk);
    chk("R7 flush ready", 32'(cell_ready), 0);
    chk("R7 flush drops", 32'(drop_count), 0);
    chk("R7 flush data", 32'(rd_data), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule